// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block shifts words out over a two-wire synchronous link on which it is the clock master. It drives a shift clock line and a data line itself, and the link is half-duplex: while the transmitter is enabled, the block tells the neighbouring receiver to stay off the line.

The host writes a word into a holding register. As soon as the internal shift register is empty, the word moves across in one clock. The holding-empty flag then rises, and the host may write the next word while the current one is still being shifted out. The holding-empty flag is set by hardware only, and only a new write clears it. Its interrupt output is gated by a separate enable. The shifter-empty bit has no interrupt and is meant to be polled.

Words are 8 bits, or 9 bits when the host asks for a ninth bit. The ninth bit and the frame length are captured together with the data byte at the moment of the write. The bit period is set by a divisor input.

Top module: `sync_tx_master`

## Requirements
- R1: After reset, `hold_empty` = 1, `shift_empty` = 1, `ser_clk` = 0 and `ser_dat` = 0.
- R2: A word is shifted only when `port_en`, `sync_sel`, `master_sel` and `tx_en` are all 1. `line_oe` = `port_en & sync_sel & master_sel`. A word written while any enable is 0 stays in the holding register.
- R3: One bit period is 4*(`cfg_div`+1) clocks. `ser_clk` is low for the first 2*(`cfg_div`+1) clocks of each bit and high for the last 2*(`cfg_div`+1) clocks.
- R4: Bits leave least-significant first. `ser_dat` changes only while `ser_clk` is low and is stable while `ser_clk` is high. Both lines rest at 0 between words.
- R5: A write to an empty holding register with the shifter empty and enabled is transferred at the next clock edge. At that edge `hold_empty` returns to 1 and `shift_empty` goes to 0.
- R6: Only a write (`wr_en` = 1) clears `hold_empty`, and `int_en` does not affect the flag. `tx_irq` = `hold_empty & int_en`.
- R7: While a word is shifting, a waiting word is not moved until the last bit of the current word has finished. Words leave in the order they were written.
- R8: When `nine_bit` = 1 at the write, the frame is 9 bits and the last bit sent is the `bit9_in` value captured at that write.
- R9: `shift_empty` rises on the same clock edge at which `ser_clk` falls after the last bit.
- R10: Clearing `tx_en` during a word aborts it. At the next edge `ser_clk` = 0, `ser_dat` = 0 and `shift_empty` = 1.
- R11: `rx_inhibit` = 1 exactly when all four enables of R2 are 1.
- R12: When `nine_bit` = 0 at the write, exactly 8 bits are sent and `bit9_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Bit-rate divisor; bit period is 4*(cfg_div+1) clocks |
| port_en | input | 1 | Serial port enable |
| sync_sel | input | 1 | Synchronous mode select |
| master_sel | input | 1 | Clock-master select |
| tx_en | input | 1 | Transmit enable; clearing it aborts a word |
| int_en | input | 1 | Interrupt enable for the holding-empty flag |
| nine_bit | input | 1 | Frame length select captured at write (1 = 9 bits) |
| bit9_in | input | 1 | Ninth data bit captured at write |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Data word to load |
| ser_clk | output | 1 | Shift clock line |
| ser_dat | output | 1 | Serial data line |
| line_oe | output | 1 | Both lines are owned by the port |
| rx_inhibit | output | 1 | Receiver must stay off the line |
| hold_empty | output | 1 | Holding register is empty |
| tx_irq | output | 1 | Holding-empty interrupt request |
| shift_empty | output | 1 | Shift register is empty |

## Verification
A write sampled at edge E0 clears `hold_empty` at E0, and the transfer at E1 sets it again and clears `shift_empty`. The bench therefore checks the flags at the falling clock after each of those two edges. Serial results have no fixed latency from the write: a scoreboard monitor samples `ser_dat` at the falling system clock that follows each `ser_clk` rise, counts the clocks `ser_clk` stays high against 2*(`cfg_div`+1), and compares the collected frame when `shift_empty` rises, in the same sample in which `ser_clk` is seen falling. Abort and gating effects are checked at the falling clock after the edge that follows the change of the enable.

// File: rtl/stx_pkg.sv
package stx_pkg;
   // Phase of the generated shift clock within one bit period
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } stx_phase_e;

   localparam int STX_MIN_DATA_W = 2;
endpackage

// File: rtl/stx_baud.sv
// Half-bit tick generator: one pulse every 2*(div+1) clocks while running.
module stx_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             half_tick
);
   localparam int CNT_W = DIV_W + 1;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("stx_baud: DIV_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit     = {div, 1'b1};
   assign half_tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || restart || half_tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/stx_holding.sv
// Host-written holding register with hardware-managed full state.
module stx_holding #(
   parameter int DATA_W    = 8,
   parameter bit HAS_NINTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ninth_en,
   input  logic              wr_ninth,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data,
   output logic              ninth_en,
   output logic              ninth
);
   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (wr_en) begin
            full_q <= 1'b1;
            data_q <= wr_data;
         end else if (take) begin
            full_q <= 1'b0;
         end
      end
   end

   generate
      if (HAS_NINTH) begin : g_ninth
         logic ninth_en_q;
         logic ninth_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ninth_en_q <= 1'b0;
               ninth_q    <= 1'b0;
            end else if (wr_en) begin
               ninth_en_q <= wr_ninth_en;
               ninth_q    <= wr_ninth & wr_ninth_en;
            end
         end
         assign ninth_en = ninth_en_q;
         assign ninth    = ninth_q;
      end else begin : g_no_ninth
         logic unused_ninth;
         assign unused_ninth = wr_ninth_en ^ wr_ninth;
         assign ninth_en     = 1'b0;
         assign ninth        = 1'b0;
      end
   endgenerate

   assign full = full_q;
   assign data = data_q;

   // R6: the register only becomes full through a host write
   a_r6_full_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> $past(wr_en));
endmodule

// File: rtl/stx_shifter.sv
// Shift register with its own clock phase and bit counter.
module stx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_ninth_en,
   input  logic              ld_ninth,
   input  logic              half_tick,
   output logic              busy,
   output logic              ser_clk,
   output logic              ser_dat
);
   import stx_pkg::*;

   localparam int FRAME_W = DATA_W + 1;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < STX_MIN_DATA_W) begin : g_bad_width
         $error("stx_shifter: DATA_W too small");
      end
   endgenerate

   logic               busy_q;
   stx_phase_e         phase_q;
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= PH_LOW;
         sh_q    <= '0;
         left_q  <= '0;
      end else if (!enable) begin
         busy_q  <= 1'b0;
         phase_q <= PH_LOW;
         sh_q    <= '0;
         left_q  <= '0;
      end else if (load) begin
         busy_q  <= 1'b1;
         phase_q <= PH_LOW;
         sh_q    <= {ld_ninth, ld_data};
         left_q  <= ld_ninth_en ? CNT_W'(FRAME_W) : CNT_W'(DATA_W);
      end else if (busy_q && half_tick) begin
         if (phase_q == PH_LOW) begin
            phase_q <= PH_HIGH;
         end else begin
            phase_q <= PH_LOW;
            sh_q    <= sh_q >> 1;
            left_q  <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign ser_clk = (phase_q == PH_HIGH);
   assign ser_dat = busy_q & sh_q[0];

   // R3: clock rests low whenever no word is in the shifter
   a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (phase_q == PH_LOW));
   // R4: data bit holds for the whole high phase
   a_r4_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HIGH && $past(phase_q) == PH_HIGH) |-> $stable(sh_q[0]));
   // R8: a fresh word holds either 8 or 9 bits
   a_r8_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (left_q == CNT_W'(DATA_W) || left_q == CNT_W'(FRAME_W)));
endmodule

// File: rtl/sync_tx_master.sv
module sync_tx_master #(
   parameter int DIV_W     = 8,
   parameter int DATA_W    = 8,
   parameter bit HAS_NINTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              port_en,
   input  logic              sync_sel,
   input  logic              master_sel,
   input  logic              tx_en,
   input  logic              int_en,
   input  logic              nine_bit,
   input  logic              bit9_in,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              line_oe,
   output logic              rx_inhibit,
   output logic              hold_empty,
   output logic              tx_irq,
   output logic              shift_empty
);
   logic              active;
   logic              xmit_ok;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              hold_ninth_en;
   logic              hold_ninth;
   logic              busy;
   logic              load;
   logic              half_tick;

   assign active  = port_en & sync_sel & master_sel;
   assign xmit_ok = active & tx_en;
   assign load    = xmit_ok & hold_full & ~busy;

   stx_holding #(.DATA_W(DATA_W), .HAS_NINTH(HAS_NINTH)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .wr_ninth_en (nine_bit),
      .wr_ninth    (bit9_in),
      .take        (load),
      .full        (hold_full),
      .data        (hold_data),
      .ninth_en    (hold_ninth_en),
      .ninth       (hold_ninth)
   );

   stx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .restart   (load),
      .div       (cfg_div),
      .half_tick (half_tick)
   );

   stx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (xmit_ok),
      .load        (load),
      .ld_data     (hold_data),
      .ld_ninth_en (hold_ninth_en),
      .ld_ninth    (hold_ninth),
      .half_tick   (half_tick),
      .busy        (busy),
      .ser_clk     (ser_clk),
      .ser_dat     (ser_dat)
   );

   assign line_oe     = active;
   assign rx_inhibit  = xmit_ok;
   assign hold_empty  = ~hold_full;
   assign tx_irq      = hold_empty & int_en;
   assign shift_empty = ~busy;

   // R5: emptying the holding register always starts the shifter
   a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> $fell(shift_empty));
   // R10: losing an enable empties the shifter at the next edge
   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !xmit_ok |=> shift_empty);
endmodule

// File: tb/sim_sync_tx_master.sv
module sim_sync_tx_master;
   localparam int DIV_W  = 8;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DIV_W-1:0]  cfg_div = 8'd1;
   logic              port_en = 1'b0, sync_sel = 1'b0, master_sel = 1'b0, tx_en = 1'b0;
   logic              int_en = 1'b0, nine_bit = 1'b0, bit9_in = 1'b0, wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              ser_clk, ser_dat, line_oe, rx_inhibit, hold_empty, tx_irq, shift_empty;

   sync_tx_master #(.DIV_W(DIV_W), .DATA_W(DATA_W), .HAS_NINTH(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .port_en(port_en),
      .sync_sel(sync_sel), .master_sel(master_sel), .tx_en(tx_en), .int_en(int_en),
      .nine_bit(nine_bit), .bit9_in(bit9_in), .wr_en(wr_en), .wr_data(wr_data),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .line_oe(line_oe), .rx_inhibit(rx_inhibit),
      .hold_empty(hold_empty), .tx_irq(tx_irq), .shift_empty(shift_empty)
   );

   always #2 clk = ~clk;   // 250 MHz

   int tests = 0, fails = 0;
   bit finished = 0;
   logic [8:0] exp_val[$];
   int         exp_len[$];
   bit         abort_f = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // Driver: waits for room, writes one word and records the expected frame
   task automatic send(input logic [7:0] d, input bit nine, input bit b9);
      while (!hold_empty) @(negedge clk);
      nine_bit = nine; bit9_in = b9; wr_data = d; wr_en = 1'b1;
      exp_val.push_back(nine ? {b9, d} : {1'b0, d});
      exp_len.push_back(nine ? 9 : 8);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drain();
      while (exp_val.size() != 0 || !shift_empty || !hold_empty) @(negedge clk);
   endtask

   // Monitor: collects bits at each clock rise and scores completed frames
   logic [8:0] got;
   int  nb = 0, hi = 0;
   bit  p_clk = 0, p_se = 1, glitch = 0, cap = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_clk && !p_clk) begin
            if (nb < 9) got[nb] = ser_dat;
            cap = ser_dat; nb++;
         end else if (ser_clk && p_clk && ser_dat != cap) begin
            glitch = 1;
         end
         if (ser_clk) hi++;
         if (!ser_clk && p_clk) begin
            if (!abort_f) chk(hi == 2 * (int'(cfg_div) + 1), "R3 high width", hi, 2 * (int'(cfg_div) + 1));
            hi = 0;
         end
         if (!shift_empty && p_se) begin nb = 0; got = '0; glitch = 0; end
         if (shift_empty && !p_se) begin
            if (abort_f) begin
               void'(exp_val.pop_front()); void'(exp_len.pop_front());
               abort_f = 0;
            end else if (exp_val.size() == 0) begin
               chk(0, "R7 unexpected frame", int'(got), 0);
            end else begin
               logic [8:0] ev;
               int el;
               ev = exp_val.pop_front(); el = exp_len.pop_front();
               if (el == 8) got[8] = 1'b0;
               chk(nb == el, "R8/R12 frame length", nb, el);
               chk(got == ev, "R4/R7 frame bits lsb first", int'(got), int'(ev));
               chk(!glitch, "R4 data stable while clock high", glitch, 0);
               chk(!ser_clk && p_clk, "R9 empty with last fall", p_clk, 1);
               chk(ser_dat == 1'b0, "R4 data idles low", ser_dat, 0);
            end
         end
         p_clk = ser_clk; p_se = shift_empty;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      wrap_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hold_empty == 1, "R1 hold_empty", hold_empty, 1);
      chk(shift_empty == 1, "R1 shift_empty", shift_empty, 1);
      chk(ser_clk == 0 && ser_dat == 0, "R1 lines idle", {ser_clk, ser_dat}, 0);
      chk(tx_irq == 0, "R6 irq masked", tx_irq, 0);
      int_en = 1'b1;
      @(negedge clk);
      chk(tx_irq == 1, "R6 irq follows flag", tx_irq, 1);

      // Enables: master select still off
      port_en = 1; sync_sel = 1; tx_en = 1;
      @(negedge clk);
      chk(line_oe == 0 && rx_inhibit == 0, "R2/R11 partial enable", {line_oe, rx_inhibit}, 0);
      send(8'h5A, 0, 1);
      repeat (30) @(negedge clk);
      chk(shift_empty == 1 && hold_empty == 0, "R2 held without master", {shift_empty, hold_empty}, 2'b10);
      chk(tx_irq == 0, "R6 irq off when full", tx_irq, 0);
      master_sel = 1;
      @(negedge clk);
      chk(line_oe == 1 && rx_inhibit == 1, "R2/R11 full enable", {line_oe, rx_inhibit}, 2'b11);
      drain();
      repeat (50) @(negedge clk);
      chk(hold_empty == 1, "R6 flag persists", hold_empty, 1);

      // Exact handoff timing
      nine_bit = 1; bit9_in = 1; wr_data = 8'hC3; wr_en = 1;
      exp_val.push_back({1'b1, 8'hC3}); exp_len.push_back(9);
      @(negedge clk);
      wr_en = 0;
      chk(hold_empty == 0, "R6 cleared by write", hold_empty, 0);
      @(negedge clk);
      chk(hold_empty == 1 && shift_empty == 0, "R5 transfer next edge", {hold_empty, shift_empty}, 2'b10);
      drain();

      // Back-to-back words
      send(8'h81, 0, 0);
      send(8'h3E, 1, 0);
      repeat (4) @(negedge clk);
      chk(hold_empty == 0 && shift_empty == 0, "R7 second word waits", {hold_empty, shift_empty}, 0);
      send(8'hF0, 1, 1);
      drain();

      // Slower divisor
      cfg_div = 8'd3;
      send(8'h96, 0, 1);
      drain();
      cfg_div = 8'd1;

      // Abort mid-word
      send(8'hA5, 1, 1);
      while (shift_empty) @(negedge clk);
      repeat (40) @(negedge clk);
      abort_f = 1; tx_en = 0;
      @(negedge clk);
      chk(ser_clk == 0 && ser_dat == 0 && shift_empty == 1, "R10 abort to idle",
          {ser_clk, ser_dat, shift_empty}, 3'b001);
      chk(rx_inhibit == 0, "R11 released", rx_inhibit, 0);
      send(8'h3C, 0, 1);
      repeat (30) @(negedge clk);
      chk(hold_empty == 0 && shift_empty == 1, "R10 word kept while disabled", {hold_empty, shift_empty}, 2'b01);
      tx_en = 1;
      drain();
      repeat (10) @(negedge clk);
      chk(ser_clk == 0 && ser_dat == 0, "R4 lines idle after words", {ser_clk, ser_dat}, 0);
      wrap_up();
   end
endmodule